// File: doc/BRIEF.md
# Self-Correcting Triple-Redundant Register Bank

This block stores a word of slowly changing state as three identical copies, one flop per bit per copy. It is meant for control and configuration values that are written rarely and then held for long stretches with the write enable low. A bit-wise two-out-of-three vote of the copies gives the output word. Each copy's next value is taken from that vote whenever no write is in progress.

A second comparator per copy and per bit flags a copy whose bit differs from the voted value. This flag raises that copy's own clock enable. A copy struck by an upset is therefore reloaded from the vote at the next clock edge, without waiting for a functional write. Per-copy error flags and a sticky correction-event flag report that a repair took place. A flip mask lets a test invert any copy of any bit at a chosen edge.

Top module: `tmr_regbank`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, all three copies load `wr_data`, and `rd_data` equals that value after the edge.
- R2: When `wr_en` is low and no copy disagrees with the vote, every copy and `rd_data` keep their value across the edge, whatever `wr_data` is.
- R3: `rd_data` is the bit-wise majority of the three copies, so a single corrupted copy of a bit never changes `rd_data`.
- R4: `copy_err[k]` is high while copy k (k = 0, 1, 2) differs from the majority in at least one bit.
- R5: A copy that disagrees with the majority is reloaded with the voted value at the next rising edge, even with `wr_en` low, so `copy_err` returns to zero one edge after the mismatch appears.
- R6: `clr` high clears all copies and the correction-event flag at once, without a clock edge, and takes priority over `pre`.
- R7: `pre` high with `clr` low sets all copies to all ones at once, without a clock edge, and leaves the correction-event flag alone.
- R8: Bit `k*WIDTH+i` of `flip_mask` high at a rising edge inverts bit i of copy k relative to the value that copy would otherwise load at that edge.
- R9: `corr_evt` is set at any rising edge where some `copy_err` bit is high. It stays set until a rising edge with `evt_clr` high and no `copy_err` bit high. When both happen at the same edge, the set wins.
- R10: Each bit is voted and repaired on its own. Single flips placed in different copies at different bits leave `rd_data` unchanged, and all of them are repaired at the same next edge.
- R11: If two copies of the same bit are flipped at the same edge, `rd_data` takes the flipped value, and at the following edge the remaining copy is overwritten to match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous clear, active high, dominant |
| pre | input | 1 | Asynchronous preset to all ones, active high |
| wr_en | input | 1 | Functional write enable |
| wr_data | input | WIDTH | Value to write |
| flip_mask | input | 3*WIDTH | Test-only upset injection; bit k*WIDTH+i targets copy k, bit i |
| evt_clr | input | 1 | Clears the sticky correction-event flag |
| rd_data | output | WIDTH | Majority-voted stored word |
| copy_err | output | 3 | Per-copy disagreement flags |
| corr_evt | output | 1 | Sticky flag, set when a repair occurred |

## Verification
The bench inverts single copies while the write enable is low. A design that only repairs on writes would leave `copy_err` high for good, and one with a broken vote would let `rd_data` move. It places flips in all three copies at different bits at once, to catch voting that is shared across bits. It applies two flips to the same bit, to confirm that the new majority spreads to the third copy rather than the old value returning. It also covers a flip that lands on a write edge, clear and preset asserted together, and an event clear issued at the same edge as a new error, where a design that lets the clear win would lose the event.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NCOPY = 3;

    typedef logic [NCOPY-1:0] trip_t;

    typedef struct packed {
        logic  voted;
        trip_t mismatch;
    } bit_stat_t;

    function automatic logic maj3(input trip_t v);
        return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
    endfunction

    function automatic trip_t minority(input trip_t v);
        logic  m;
        trip_t r;
        m = maj3(v);
        for (int k = 0; k < NCOPY; k++) begin
            r[k] = v[k] ^ m;
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr_copy_ff.sv
module tmr_copy_ff (
    input  logic clk,
    input  logic clr,
    input  logic pre,
    input  logic ce,
    input  logic d,
    input  logic flip,
    output logic q
);

    always_ff @(posedge clk or posedge clr or posedge pre) begin
        if (clr) begin
            q <= 1'b0;
        end else if (pre) begin
            q <= 1'b1;
        end else begin
            q <= (ce ? d : q) ^ flip;
        end
    end

endmodule

// File: rtl/tmr_bit_cell.sv
module tmr_bit_cell
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      clr,
    input  logic      pre,
    input  logic      wr_en,
    input  logic      wr_bit,
    input  trip_t     flip,
    output bit_stat_t stat
);

    trip_t copies;
    trip_t miss;
    logic  voted;

    assign voted = maj3(copies);
    assign miss  = minority(copies);

    for (genvar k = 0; k < NCOPY; k++) begin : g_copy
        logic eff_ce;
        logic nxt;
        assign eff_ce = wr_en | miss[k];
        assign nxt    = wr_en ? wr_bit : voted;

        tmr_copy_ff u_ff (
            .clk  (clk),
            .clr  (clr),
            .pre  (pre),
            .ce   (eff_ce),
            .d    (nxt),
            .flip (flip[k]),
            .q    (copies[k])
        );
    end

    assign stat.voted    = voted;
    assign stat.mismatch = miss;

endmodule

// File: rtl/tmr_event_flag.sv
module tmr_event_flag (
    input  logic clk,
    input  logic clr,
    input  logic set_i,
    input  logic clear_i,
    output logic flag
);

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            flag <= 1'b0;
        end else if (set_i) begin
            flag <= 1'b1;
        end else if (clear_i) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
    import tmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               pre,
    input  logic               wr_en,
    input  logic [WIDTH-1:0]   wr_data,
    input  logic [3*WIDTH-1:0] flip_mask,
    input  logic               evt_clr,
    output logic [WIDTH-1:0]   rd_data,
    output logic [2:0]         copy_err,
    output logic               corr_evt
);

    localparam int FLIPW = NCOPY * WIDTH;

    bit_stat_t            stat [WIDTH];
    logic [WIDTH-1:0]     miss_by_copy [NCOPY];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        trip_t flip_bits;
        for (genvar k = 0; k < NCOPY; k++) begin : g_sel
            assign flip_bits[k] = flip_mask[k*WIDTH + i];
        end

        tmr_bit_cell u_cell (
            .clk    (clk),
            .clr    (clr),
            .pre    (pre),
            .wr_en  (wr_en),
            .wr_bit (wr_data[i]),
            .flip   (flip_bits),
            .stat   (stat[i])
        );

        assign rd_data[i] = stat[i].voted;
        for (genvar k = 0; k < NCOPY; k++) begin : g_miss
            assign miss_by_copy[k][i] = stat[i].mismatch[k];
        end
    end

    for (genvar k = 0; k < NCOPY; k++) begin : g_err
        assign copy_err[k] = |miss_by_copy[k];
    end

    tmr_event_flag u_evt (
        .clk     (clk),
        .clr     (clr),
        .set_i   (|copy_err),
        .clear_i (evt_clr),
        .flag    (corr_evt)
    );

    if (FLIPW != 3 * WIDTH) begin : g_bad_width
        initial $error("flip mask width mismatch");
    end

endmodule

// File: rtl/tmr_regbank_chk.sv
module tmr_regbank_chk #(
    parameter int WIDTH = 16
) (
    input logic               clk,
    input logic               clr,
    input logic               pre,
    input logic               wr_en,
    input logic [WIDTH-1:0]   wr_data,
    input logic [3*WIDTH-1:0] flip_mask,
    input logic [WIDTH-1:0]   rd_data,
    input logic [2:0]         copy_err,
    input logic               corr_evt
);

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (clr || pre)
        (wr_en && flip_mask == '0) |=> rd_data == $past(wr_data)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr || pre)
        (!wr_en && flip_mask == '0 && copy_err == '0) |=> $stable(rd_data)); // R2

    AST_SINGLE_MASKED: assert property (@(posedge clk) disable iff (clr || pre)
        (!wr_en && copy_err == '0 && $countones(flip_mask) <= 1) |=> $stable(rd_data)); // R3

    AST_SINGLE_FLAG: assert property (@(posedge clk) disable iff (clr || pre)
        (copy_err == '0 && $countones(flip_mask) == 1) |=> $onehot0(copy_err)); // R4

    AST_SELF_REPAIR: assert property (@(posedge clk) disable iff (clr || pre)
        (copy_err != '0 && flip_mask == '0) |=> copy_err == '0); // R5

    AST_CLEAR_DOMINANT: assert property (@(posedge clk)
        clr |-> (rd_data == '0 && copy_err == '0 && !corr_evt)); // R6

    AST_PRESET_ONES: assert property (@(posedge clk)
        (pre && !clr) |-> (rd_data == '1 && copy_err == '0)); // R7

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (clr)
        (copy_err != '0) |=> corr_evt); // R9

endmodule

bind tmr_regbank tmr_regbank_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .clr       (clr),
    .pre       (pre),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .flip_mask (flip_mask),
    .rd_data   (rd_data),
    .copy_err  (copy_err),
    .corr_evt  (corr_evt)
);

// File: tb/tmr_regbank_tb.sv
module tmr_regbank_tb;

    localparam int CLK_P = 10;
    localparam int W     = 8;

    logic           clk = 1'b0;
    logic           clr = 1'b0;
    logic           pre = 1'b0;
    logic           wr_en = 1'b0;
    logic [W-1:0]   wr_data = '0;
    logic [3*W-1:0] flip_mask = '0;
    logic           evt_clr = 1'b0;
    logic [W-1:0]   rd_data;
    logic [2:0]     copy_err;
    logic           corr_evt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [W-1:0] d;
        logic [2:0]   e;
        logic         v;
        string        tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    tmr_regbank #(.WIDTH(W)) u_dut (
        .clk       (clk),
        .clr       (clr),
        .pre       (pre),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .flip_mask (flip_mask),
        .evt_clr   (evt_clr),
        .rd_data   (rd_data),
        .copy_err  (copy_err),
        .corr_evt  (corr_evt)
    );

    function automatic logic [3*W-1:0] fl(input int copy, input int b);
        logic [3*W-1:0] m;
        m = '0;
        m[copy*W + b] = 1'b1;
        return m;
    endfunction

    task automatic expect_out(input logic [W-1:0] d, input logic [2:0] e,
                              input logic v, input string tag);
        exp_t x;
        x.d = d; x.e = e; x.v = v; x.tag = tag;
        sb.push_back(x);
    endtask

    task automatic step(input logic en, input logic [W-1:0] d,
                        input logic [3*W-1:0] fm, input logic ec);
        @(negedge clk);
        #1;
        wr_en = en; wr_data = d; flip_mask = fm; evt_clr = ec;
        @(posedge clk);
        #1;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                checks++;
                if (rd_data !== x.d || copy_err !== x.e || corr_evt !== x.v) begin
                    errors++;
                    $display("FAIL %s: got data=%h err=%b evt=%b, expected data=%h err=%b evt=%b",
                             x.tag, rd_data, copy_err, corr_evt, x.d, x.e, x.v);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R6: clear and preset together, clear wins
        @(negedge clk); #1;
        clr = 1'b1; pre = 1'b1;
        #1 expect_out(8'h00, 3'b000, 1'b0, "R6 reset state, clr over pre");
        @(negedge clk); #1 pre = 1'b0;
        @(negedge clk); #1 clr = 1'b0;

        // R1: write
        step(1'b1, 8'hA5, '0, 1'b0);
        expect_out(8'hA5, 3'b000, 1'b0, "R1 write loads");

        // R2: hold, wr_data ignored
        step(1'b0, 8'h3C, '0, 1'b0);
        expect_out(8'hA5, 3'b000, 1'b0, "R2 hold with enable low");
        step(1'b0, 8'hFF, '0, 1'b0);
        expect_out(8'hA5, 3'b000, 1'b0, "R2 hold second cycle");

        // R8/R3/R4: flip copy 1 bit 0
        step(1'b0, 8'h3C, fl(1, 0), 1'b0);
        expect_out(8'hA5, 3'b010, 1'b0, "R8 R3 R4 single flip copy1");
        // R5/R9: repaired next edge, event set
        step(1'b0, 8'h3C, '0, 1'b0);
        expect_out(8'hA5, 3'b000, 1'b1, "R5 R9 repair and event");
        // R9: clear event
        step(1'b0, 8'h3C, '0, 1'b1);
        expect_out(8'hA5, 3'b000, 1'b0, "R9 event cleared");

        // R10: flips in all copies at different bits
        step(1'b0, 8'h00, fl(0, 1) | fl(1, 4) | fl(2, 7), 1'b0);
        expect_out(8'hA5, 3'b111, 1'b0, "R10 three flips masked");
        step(1'b0, 8'h00, '0, 1'b0);
        expect_out(8'hA5, 3'b000, 1'b1, "R10 all repaired together");
        step(1'b0, 8'h00, '0, 1'b1);
        expect_out(8'hA5, 3'b000, 1'b0, "R9 clear again");

        // R9: clear at the same edge as an error, set wins
        step(1'b0, 8'h00, fl(0, 2), 1'b0);
        expect_out(8'hA5, 3'b001, 1'b0, "R4 flip copy0");
        step(1'b0, 8'h00, '0, 1'b1);
        expect_out(8'hA5, 3'b000, 1'b1, "R9 set wins over clear");

        // R11: double fault on bit 0 (stored 1)
        step(1'b0, 8'h00, fl(0, 0) | fl(1, 0), 1'b0);
        expect_out(8'hA4, 3'b100, 1'b1, "R11 two copies flipped");
        step(1'b0, 8'h00, '0, 1'b0);
        expect_out(8'hA4, 3'b000, 1'b1, "R11 third copy follows");

        // R8 during write: copy2 bit 3 inverted relative to loaded value
        step(1'b1, 8'h5A, fl(2, 3), 1'b0);
        expect_out(8'h5A, 3'b100, 1'b1, "R8 flip on write edge");
        step(1'b0, 8'h00, '0, 1'b0);
        expect_out(8'h5A, 3'b000, 1'b1, "R5 repair after write flip");

        // R7: asynchronous preset, event untouched
        @(negedge clk); #1 pre = 1'b1;
        #1 expect_out(8'hFF, 3'b000, 1'b1, "R7 preset async");
        @(negedge clk); #1 pre = 1'b0;
        step(1'b0, 8'h00, '0, 1'b0);
        expect_out(8'hFF, 3'b000, 1'b1, "R2 hold after preset");

        // R6: asynchronous clear mid-cycle
        @(negedge clk); #1 clr = 1'b1;
        #1 expect_out(8'h00, 3'b000, 1'b0, "R6 async clear");
        @(negedge clk); #1 clr = 1'b0;

        // R1 after clear
        step(1'b1, 8'h3C, '0, 1'b0);
        expect_out(8'h3C, 3'b000, 1'b0, "R1 write after clear");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule